// File: doc/BRIEF.md
# Partial-Tag Way Filter for a Set-Associative Cache

This block sits in front of the tag and data arrays of a set-associative cache and reduces the number of ways that are switched on for each lookup. For every line it keeps the low-order bits of the tag in a narrow side store. On a lookup it reads that store for the addressed set and compares each way's stored bits with the low bits of the request tag. Only ways that are valid and match on those bits are enabled. The block then reads the full tag of the enabled ways only and decides whether one of them is a real hit.

The mask, the hit flag and the hit way are combinational from the lookup inputs, so filtering adds no cycle to the access. A separate write port either fills a chosen way, writing the full tag, the valid bit and the partial bits in one edge, or invalidates a way. The write port and the lookup port are independent and can be used in the same cycle. The way enable mask is an output so that a power model can count how many ways each access activates.

Top module: `ptf_way_filter`

## Requirements
- R1: After reset every way of every set is invalid, so every lookup gives `way_en` all zero and `hit` 0.
- R2: In the cycle a lookup is presented (`lk_valid`=1), `way_en[w]` is 1 exactly when way w of set `lk_set` is valid and its stored low PART_W tag bits equal `lk_tag[PART_W-1:0]`; with `lk_valid`=0 the mask is all zero.
- R3: In the same cycle, `hit` is 1 exactly when an enabled way's full stored tag equals `lk_tag`, and `hit_way` gives that way's index; `hit_way` is 0 when `hit` is 0.
- R4: A write with `wr_valid`=1 and `wr_kind`=0 (fill) stores `wr_tag`, its low PART_W bits and a set valid bit into way `wr_way` of set `wr_set` at one clock edge; lookups see the new line from the next cycle.
- R5: A write with `wr_valid`=1 and `wr_kind`=1 (invalidate) clears the valid bit of way `wr_way` in set `wr_set`; that way is never enabled afterwards whatever its partial bits hold, and other ways keep their state.
- R6: A lookup in the same cycle as a write to the same set observes the contents from before the write.
- R7: Whenever `hit` is 1, the bit of `way_en` at `hit_way` is 1.
- R8: Several ways of a set may be enabled by one lookup; provided fills never place one full tag twice in a set, at most one enabled way matches in full.
- R9: With `wr_valid`=0 nothing is stored, whatever the other write inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request present |
| lk_set | input | SET_W | Set index of the lookup |
| lk_tag | input | TAG_W | Full tag of the lookup |
| wr_valid | input | 1 | Write request present |
| wr_kind | input | 1 | 0 = fill, 1 = invalidate |
| wr_set | input | SET_W | Set index of the write |
| wr_way | input | WAY_W | Way written (victim for a fill) |
| wr_tag | input | TAG_W | Full tag stored by a fill |
| way_en | output | WAYS | Per-way enable for the tag and data arrays |
| hit | output | 1 | Real hit among the enabled ways |
| hit_way | output | WAY_W | Index of the hitting way |

## Verification
A lookup and a write can land in the same cycle, including on the same set and the very way being read. The bench provokes this by presenting a fill or an invalidate together with a lookup of that set and tag, checks that the outputs reflect the arrays as they were before the edge, and then repeats the lookup one cycle later to confirm the write has taken effect. Every other sweep covers all sets and all tags of a small configuration against an arithmetic model kept in the bench.

// File: rtl/ptf_pkg.sv
package ptf_pkg;

    typedef enum logic {
        WR_FILL  = 1'b0,
        WR_INVAL = 1'b1
    } wr_kind_e;

    typedef struct packed {
        logic     act;
        wr_kind_e kind;
    } wr_cmd_t;

endpackage

// File: rtl/ptf_side_array.sv
module ptf_side_array #(
    parameter int PART_W = 4,
    parameter int WAYS   = 8,
    parameter int SETS   = 64,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fill,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [PART_W-1:0] wr_part,
    input  logic              rd_act,
    input  logic [SET_W-1:0]  rd_set,
    input  logic [PART_W-1:0] rd_part,
    input  logic [WAYS-1:0]   valid_row,
    output logic [WAYS-1:0]   cand
);
    logic [PART_W-1:0] part_q [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (fill) part_q[wr_set][wr_way] <= wr_part;
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign cand[w] = rd_act && valid_row[w] && (part_q[rd_set][w] == rd_part);
    end

    AST_FILL_PART: assert property (@(posedge clk) disable iff (rst)
        fill |=> part_q[$past(wr_set)][$past(wr_way)] == $past(wr_part)); // R4
endmodule

// File: rtl/ptf_tag_store.sv
module ptf_tag_store #(
    parameter int WAYS   = 8,
    parameter int SETS   = 64,
    parameter int TAG_W  = 20,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  ptf_pkg::wr_cmd_t  cmd,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [SET_W-1:0]  rd_set,
    input  logic [WAYS-1:0]   rd_en,
    output logic [WAYS-1:0]   valid_row,
    output logic [TAG_W-1:0]  rd_tag [WAYS]
);
    import ptf_pkg::*;

    logic [WAYS-1:0]  valid_q [SETS];
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else if (cmd.act) begin
            valid_q[wr_set][wr_way] <= (cmd.kind == WR_FILL);
        end
    end

    always_ff @(posedge clk) begin
        if (cmd.act && cmd.kind == WR_FILL) tag_q[wr_set][wr_way] <= wr_tag;
    end

    assign valid_row = valid_q[rd_set];

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_tag[w] = rd_en[w] ? tag_q[rd_set][w] : '0;
    end

    AST_INVAL_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (cmd.act && cmd.kind == WR_INVAL) |=> !valid_q[$past(wr_set)][$past(wr_way)]); // R5
    AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (rst)
        (cmd.act && cmd.kind == WR_FILL) |=> valid_q[$past(wr_set)][$past(wr_way)]); // R4
endmodule

// File: rtl/ptf_hit_resolve.sv
module ptf_hit_resolve #(
    parameter int WAYS   = 8,
    parameter int TAG_W  = 20,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WAYS-1:0]   en,
    input  logic [TAG_W-1:0]  tags [WAYS],
    input  logic [TAG_W-1:0]  req_tag,
    output logic              hit,
    output logic [WAY_W-1:0]  hit_way
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_full
        assign match[w] = en[w] && (tags[w] == req_tag);
    end

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit = |match;

    AST_ONE_FULL_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match)); // R8
endmodule

// File: rtl/ptf_way_filter.sv
module ptf_way_filter #(
    parameter int PART_W = 4,
    parameter int WAYS   = 8,
    parameter int SETS   = 64,
    parameter int TAG_W  = 20,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_valid,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic             wr_valid,
    input  logic             wr_kind,
    input  logic [SET_W-1:0] wr_set,
    input  logic [WAY_W-1:0] wr_way,
    input  logic [TAG_W-1:0] wr_tag,
    output logic [WAYS-1:0]  way_en,
    output logic             hit,
    output logic [WAY_W-1:0] hit_way
);
    import ptf_pkg::*;

    wr_cmd_t          cmd;
    logic [WAYS-1:0]  valid_row;
    logic [TAG_W-1:0] rd_tag [WAYS];

    assign cmd.act  = wr_valid;
    assign cmd.kind = wr_kind_e'(wr_kind);

    ptf_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst(rst), .cmd(cmd),
        .wr_set(wr_set), .wr_way(wr_way), .wr_tag(wr_tag),
        .rd_set(lk_set), .rd_en(way_en),
        .valid_row(valid_row), .rd_tag(rd_tag)
    );

    ptf_side_array #(.PART_W(PART_W), .WAYS(WAYS), .SETS(SETS)) u_side (
        .clk(clk), .rst(rst),
        .fill(wr_valid && cmd.kind == WR_FILL),
        .wr_set(wr_set), .wr_way(wr_way), .wr_part(wr_tag[PART_W-1:0]),
        .rd_act(lk_valid), .rd_set(lk_set), .rd_part(lk_tag[PART_W-1:0]),
        .valid_row(valid_row), .cand(way_en)
    );

    ptf_hit_resolve #(.WAYS(WAYS), .TAG_W(TAG_W)) u_hit (
        .clk(clk), .rst(rst), .en(way_en), .tags(rd_tag),
        .req_tag(lk_tag), .hit(hit), .hit_way(hit_way)
    );

    AST_HIT_IN_MASK: assert property (@(posedge clk) disable iff (rst)
        hit |-> way_en[hit_way]); // R7
    AST_EN_ONLY_VALID: assert property (@(posedge clk) disable iff (rst)
        (way_en & ~valid_row) == '0); // R5
    AST_IDLE_NO_EN: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> (way_en == '0 && !hit)); // R2
    AST_NO_HIT_ZERO_WAY: assert property (@(posedge clk) disable iff (rst)
        !hit |-> hit_way == '0); // R3
endmodule

// File: tb/ptf_way_filter_bench.sv
module ptf_way_filter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 2;
    localparam int NW = 4;
    localparam int NS = 4;
    localparam int TW = 6;
    localparam int SW = $clog2(NS);
    localparam int WW = $clog2(NW);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lk_valid = 1'b0;
    logic [SW-1:0] lk_set = '0;
    logic [TW-1:0] lk_tag = '0;
    logic          wr_valid = 1'b0;
    logic          wr_kind = 1'b0;
    logic [SW-1:0] wr_set = '0;
    logic [WW-1:0] wr_way = '0;
    logic [TW-1:0] wr_tag = '0;
    logic [NW-1:0] way_en;
    logic          hit;
    logic [WW-1:0] hit_way;

    int tests = 0;
    int fails = 0;
    int multi_en = 0;
    bit done = 1'b0;

    logic [TW-1:0] m_tag [NS][NW];
    logic          m_val [NS][NW];

    always #(CLK_PERIOD/2) clk = ~clk;

    ptf_way_filter #(.PART_W(PW), .WAYS(NW), .SETS(NS), .TAG_W(TW)) u_ptf_way_filter (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_set(lk_set), .lk_tag(lk_tag),
        .wr_valid(wr_valid), .wr_kind(wr_kind), .wr_set(wr_set), .wr_way(wr_way),
        .wr_tag(wr_tag), .way_en(way_en), .hit(hit), .hit_way(hit_way)
    );

    function automatic logic [TW-1:0] fill_tag(int s, int w, int salt);
        return TW'(((((w * 5 + s + salt) & 15)) << 2) | (((w >> 1) ^ s) & 3));
    endfunction

    task automatic check_lookup(string req, int s, int t);
        logic [NW-1:0] e_en;
        logic          e_hit;
        logic [WW-1:0] e_way;
        int            n;
        e_en = '0; e_hit = 1'b0; e_way = '0; n = 0;
        for (int w = 0; w < NW; w++) begin
            if (m_val[s][w] && m_tag[s][w][PW-1:0] == TW'(t) % (1 << PW)) begin
                e_en[w] = 1'b1;
                n++;
                if (m_tag[s][w] == TW'(t)) begin
                    e_hit = 1'b1;
                    e_way = WW'(w);
                end
            end
        end
        if (n > 1) multi_en++;
        tests++;
        if (way_en !== e_en || hit !== e_hit || hit_way !== e_way) begin
            fails++;
            $display("FAIL %s set=%0d tag=%0d: en=%b hit=%b way=%0d expected en=%b hit=%b way=%0d",
                     req, s, t, way_en, hit, hit_way, e_en, e_hit, e_way);
        end
    endtask

    task automatic sweep(string req);
        for (int s = 0; s < NS; s++) begin
            for (int t = 0; t < (1 << TW); t++) begin
                @(negedge clk);
                lk_valid = 1'b1; lk_set = SW'(s); lk_tag = TW'(t);
                #1;
                check_lookup(req, s, t);
            end
        end
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic do_write(logic kind, int s, int w, logic [TW-1:0] tg);
        @(negedge clk);
        wr_valid = 1'b1; wr_kind = kind; wr_set = SW'(s); wr_way = WW'(w); wr_tag = tg;
        @(negedge clk);
        wr_valid = 1'b0;
        if (kind == 1'b0) begin
            m_tag[s][w] = tg; m_val[s][w] = 1'b1;
        end else begin
            m_val[s][w] = 1'b0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) begin
                m_val[s][w] = 1'b0; m_tag[s][w] = '0;
            end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: everything invalid after reset
        sweep("R1");

        // R4: fill every way; R2 R3 R8 over all lookups
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++)
                do_write(1'b0, s, w, fill_tag(s, w, 0));
        sweep("R2 R3 R4");

        tests++;
        if (multi_en == 0) begin
            fails++;
            $display("FAIL R8: lookups with several enabled ways=%0d expected >0", multi_en);
        end

        // R5: invalidate selected ways
        do_write(1'b1, 0, 0, '0);
        do_write(1'b1, 1, 3, '0);
        do_write(1'b1, 2, 1, '0);
        do_write(1'b1, 2, 2, '0);
        sweep("R5");

        // R9: write inputs toggled with wr_valid low
        @(negedge clk);
        wr_valid = 1'b0; wr_kind = 1'b0; wr_set = '0; wr_way = '0; wr_tag = 6'h3f;
        @(negedge clk);
        wr_kind = 1'b1; wr_set = 1; wr_way = 1;
        @(negedge clk);
        sweep("R9");

        // R6: concurrent write and lookup on the same set and way
        for (int s = 0; s < NS; s++) begin
            for (int w = 0; w < NW; w++) begin
                logic [TW-1:0] nt;
                logic          kind;
                nt = fill_tag(s, w, 7);
                kind = ((s + w) % 3 == 0);
                @(negedge clk);
                wr_valid = 1'b1; wr_kind = kind; wr_set = SW'(s); wr_way = WW'(w); wr_tag = nt;
                lk_valid = 1'b1; lk_set = SW'(s);
                lk_tag = kind ? m_tag[s][w] : nt;
                #1;
                check_lookup("R6", s, int'(lk_tag));
                @(negedge clk);
                wr_valid = 1'b0;
                if (kind) m_val[s][w] = 1'b0;
                else begin m_tag[s][w] = nt; m_val[s][w] = 1'b1; end
                #1;
                check_lookup("R6 R4 R5", s, int'(lk_tag));
            end
        end
        @(negedge clk);
        lk_valid = 1'b0;

        // R7: full sweep after the mixed updates
        sweep("R7 R3");

        // R2: no lookup means empty mask
        @(negedge clk);
        lk_valid = 1'b0; lk_set = 0; lk_tag = m_tag[0][1];
        #1;
        tests++;
        if (way_en !== '0 || hit !== 1'b0) begin
            fails++;
            $display("FAIL R2 idle: en=%b hit=%b expected en=0 hit=0", way_en, hit);
        end

        // R1: reset again clears all
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) m_val[s][w] = 1'b0;
        sweep("R1 rereset");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule